// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

This block is one channel of a software-programmed interval timer. A host writes command bytes to a control port and count bytes to a data port over an 8-bit bus. A count-enable strobe, synchronous to the system clock, advances the channel: each rising edge of the strobe moves the counter down by one. The interrupt output follows one of three behaviours: a one-shot terminal flag, a periodic rate generator, or a one-shot strobe.

Every command that selects a behaviour stops the channel at once. No further interrupt activity occurs until a complete new count has been written. This gives the host one well-defined way to silence the timer. The host can sample the running count without disturbing it, either with a count-latch command or with a read-back command. The read-back command can also capture a status byte, and that byte is returned ahead of the count bytes.

Read data leaves the block as a small stream. A read request yields exactly one byte, flagged by `rd_valid` on the following cycle. There is no back-pressure path: the host must take the byte in the cycle that `rd_valid` is high.

Top module: `tick_timer`

## Requirements
- R1: After reset the interrupt output is low and the counter is halted at 0. The access format is low-byte-then-high-byte and the behaviour is the one-shot flag, so the status byte reads 0x70.
- R2: A control byte is decoded as follows:
  - Bits [7:6] = 00 address this channel.
  - Bits [5:4] give the access format: 01 low byte only, 10 high byte only, 11 low then high; 00 means a count-latch command.
  - Bits [3:1] give the behaviour: 000 one-shot flag, 010 or 110 rate generator, 100 one-shot strobe.
  - Bit 0 is stored and reported only.
  - A control byte with bits [7:6] = 01 or 10, or with any other behaviour code, changes nothing.
- R3: A behaviour-selecting control byte halts counting and marks the count as not yet loaded. It drives the interrupt output low for the one-shot flag and high for the other two behaviours. Strobe edges leave the count unchanged until a full count is written.
- R4: A count is written in the selected access format: one byte fills the addressed half and zeroes the other, or two bytes arrive low then high. Every count byte halts counting. A complete count is loaded into the counter on the next strobe edge, and that edge does not decrement.
- R5: The counter decrements once per rising edge of the count-enable strobe, however long the strobe stays high.
- R6: One-shot flag: the output goes high on the edge at which the count reaches 0, which is N+1 strobe edges after the count write. It then stays high while the counter wraps and keeps running, until the next control or count write.
- R7: Rate generator: the output is low for one strobe interval when the count reaches 1. The next edge reloads N and restores the output high, giving a period of N edges.
- R8: One-shot strobe: the output drops for one strobe interval when the count first reaches 0. It does not drop again while the counter wraps.
- R9: An initial count of 0 counts as 65536. After loading it reads 0x0000, the next edge gives 0xFFFF, and it is not treated as terminal.
- R10: Control byte 0x00 freezes the current count for the following reads without stopping the counter. A second latch command while a latched count is unread is ignored.
- R11: In the read-back command 0xC2, bit 1 selects this channel, bit 5 = 0 latches the count and bit 4 = 0 latches the status. The following reads return status, then count low, then count high. The status byte is {output level, count-not-loaded, access[1:0], behaviour[2:0], bit 0}.
- R12: Each read request returns one byte with `rd_valid` high on the next cycle. `rd_valid` is low in every other cycle.
- R13: With no latch pending, reads return the live count: alternating low then high for format 11, and always the same half for formats 01 and 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one byte |
| wr_ctl | input | 1 | 1 selects the control port, 0 the data port |
| wr_data | input | 8 | Byte being written |
| rd_en | input | 1 | Read request for one byte from the data port |
| rd_data | output | 8 | Returned byte, valid with rd_valid |
| rd_valid | output | 1 | One-cycle flag marking rd_data |
| cnt_tick | input | 1 | Count-enable strobe; each rising edge advances the counter |
| irq_out | output | 1 | Timer output / interrupt line |

## Verification
The assertions assume that a write and a read never share a cycle; one of them checks this at the inputs. They also assume the strobe is a clean synchronous level, so that its rising edge is the only thing that moves the count.

The stimulus issues every bus access from a task that holds the strobe low and separates accesses by an idle cycle. Strobe pulses are generated only between accesses, so commands, reads and count edges never collide. Expected read bytes are queued by the driver when the request is issued, and a monitor matches them in order against the returned bytes.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_WORD  = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    OP_ONESHOT = 2'd0,
    OP_RATE    = 2'd1,
    OP_STROBE  = 2'd2,
    OP_NONE    = 2'd3
  } op_e;

  function automatic op_e decode_op(input logic [2:0] code);
    if (code == 3'b000)            return OP_ONESHOT;
    else if (code[1:0] == 2'b10)   return OP_RATE;
    else if (code == 3'b100)       return OP_STROBE;
    else                           return OP_NONE;
  endfunction
endpackage

// File: rtl/tmr_cmd_decode.sv
module tmr_cmd_decode
  import tick_timer_pkg::*;
(
  input  logic              wr_en,
  input  logic              wr_ctl,
  input  logic [BYTE_W-1:1] ctl_bits,
  output logic              mode_wr,
  output logic              latch_cmd,
  output logic              rb_cnt,
  output logic              rb_sts,
  output logic              data_wr
);
  logic ctl_wr, sel_self, sel_rb;

  always_comb begin
    ctl_wr    = wr_en && wr_ctl;
    sel_self  = ctl_bits[7:6] == 2'b00;
    sel_rb    = ctl_bits[7:6] == 2'b11;
    data_wr   = wr_en && !wr_ctl;
    latch_cmd = ctl_wr && sel_self && (ctl_bits[5:4] == ACC_LATCH);
    mode_wr   = ctl_wr && sel_self && (ctl_bits[5:4] != ACC_LATCH)
                && (decode_op(ctl_bits[3:1]) != OP_NONE);
    rb_cnt    = ctl_wr && sel_rb && ctl_bits[1] && !ctl_bits[5];
    rb_sts    = ctl_wr && sel_rb && ctl_bits[1] && !ctl_bits[4];
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic              data_wr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              tick_edge,
  output logic [CNT_W-1:0]  count,
  output logic              out,
  output acc_e              acc,
  output logic [BYTE_W-1:0] status
);
  localparam int HALF_W = CNT_W / 2;

  logic [CNT_W:0]    cnt, cnt_dec, init_eff;
  logic [HALF_W-1:0] init_lo, init_hi;
  logic [2:0]        mode_q;
  logic              bcd_q, wr_hi, load_pend, running, fired, nullc;
  op_e               op;

  always_comb begin
    op       = decode_op(mode_q);
    cnt_dec  = (cnt == '0) ? {1'b0, {CNT_W{1'b1}}} : cnt - 1'b1;
    init_eff = ({init_hi, init_lo} == '0) ? (CNT_W+1)'(1) << CNT_W
                                         : {1'b0, init_hi, init_lo};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; init_lo <= '0; init_hi <= '0;
      acc <= ACC_WORD; mode_q <= 3'b000; bcd_q <= 1'b0;
      wr_hi <= 1'b0; load_pend <= 1'b0; running <= 1'b0;
      fired <= 1'b0; nullc <= 1'b1; out <= 1'b0;
    end else if (mode_wr) begin
      acc       <= acc_e'(wr_data[5:4]);
      mode_q    <= wr_data[3:1];
      bcd_q     <= wr_data[0];
      running   <= 1'b0;
      load_pend <= 1'b0;
      nullc     <= 1'b1;
      wr_hi     <= 1'b0;
      fired     <= 1'b0;
      out       <= (decode_op(wr_data[3:1]) != OP_ONESHOT);
    end else if (data_wr) begin
      running <= 1'b0;
      nullc   <= 1'b1;
      out     <= (op != OP_ONESHOT);
      case (acc)
        ACC_LO: begin
          init_lo <= wr_data; init_hi <= '0; load_pend <= 1'b1;
        end
        ACC_HI: begin
          init_hi <= wr_data; init_lo <= '0; load_pend <= 1'b1;
        end
        default: begin
          if (!wr_hi) begin
            init_lo <= wr_data; wr_hi <= 1'b1; load_pend <= 1'b0;
          end else begin
            init_hi <= wr_data; wr_hi <= 1'b0; load_pend <= 1'b1;
          end
        end
      endcase
    end else if (tick_edge) begin
      if (load_pend) begin
        cnt       <= init_eff;
        load_pend <= 1'b0;
        running   <= 1'b1;
        nullc     <= 1'b0;
        fired     <= 1'b0;
      end else if (running) begin
        case (op)
          OP_RATE: begin
            if (cnt == (CNT_W+1)'(1)) begin
              cnt <= init_eff; out <= 1'b1;
            end else begin
              cnt <= cnt_dec;
              if (cnt_dec == (CNT_W+1)'(1)) out <= 1'b0;
            end
          end
          OP_STROBE: begin
            cnt <= cnt_dec;
            if (!out) out <= 1'b1;
            else if (cnt_dec == '0 && !fired) begin
              out <= 1'b0; fired <= 1'b1;
            end
          end
          default: begin
            cnt <= cnt_dec;
            if (cnt_dec == '0 && !fired) begin
              out <= 1'b1; fired <= 1'b1;
            end
          end
        endcase
      end
    end
  end

  assign count  = cnt[CNT_W-1:0];
  assign status = {out, nullc, acc, mode_q, bcd_q};

  assert_halt_on_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (!running && nullc));
  assert_count_moves_on_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_edge |=> $stable(cnt));
  assert_oneshot_falls_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ONESHOT && $fell(out)) |-> $past(mode_wr || data_wr));
endmodule

// File: rtl/tmr_readout.sv
module tmr_readout
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic              latch_cmd,
  input  logic              rb_cnt,
  input  logic              rb_sts,
  input  logic              rd_en,
  input  acc_e              acc,
  input  logic [CNT_W-1:0]  count,
  input  logic [BYTE_W-1:0] status,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int HALF_W = CNT_W / 2;

  logic [CNT_W-1:0]  cnt_lat, src;
  logic [BYTE_W-1:0] sts_lat;
  logic              cnt_v, sts_v, rd_hi;

  always_comb src = cnt_v ? cnt_lat : count;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_lat <= '0; sts_lat <= '0; cnt_v <= 1'b0; sts_v <= 1'b0;
      rd_hi <= 1'b0; rd_data <= '0; rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (mode_wr) begin
        cnt_v <= 1'b0; sts_v <= 1'b0; rd_hi <= 1'b0;
      end else begin
        if (rb_sts && !sts_v) begin
          sts_lat <= status; sts_v <= 1'b1;
        end
        if ((latch_cmd || rb_cnt) && !cnt_v) begin
          cnt_lat <= count; cnt_v <= 1'b1;
        end
        if (rd_en) begin
          if (sts_v) begin
            rd_data <= sts_lat; sts_v <= 1'b0;
          end else begin
            case (acc)
              ACC_HI: begin
                rd_data <= src[CNT_W-1:HALF_W]; cnt_v <= 1'b0;
              end
              ACC_WORD: begin
                rd_data <= rd_hi ? src[CNT_W-1:HALF_W] : src[HALF_W-1:0];
                rd_hi   <= !rd_hi;
                if (rd_hi) cnt_v <= 1'b0;
              end
              default: begin
                rd_data <= src[HALF_W-1:0]; cnt_v <= 1'b0;
              end
            endcase
          end
        end
      end
    end
  end

  assert_read_answers_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  assert_no_stray_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_ctl,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic              cnt_tick,
  output logic              irq_out
);
  logic             mode_wr, latch_cmd, rb_cnt, rb_sts, data_wr;
  logic             tick_q, tick_edge;
  logic [CNT_W-1:0] count;
  logic [BYTE_W-1:0] status;
  acc_e             acc;

  always_ff @(posedge clk) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= cnt_tick;
  end
  assign tick_edge = cnt_tick && !tick_q;

  tmr_cmd_decode u_dec (
    .wr_en(wr_en), .wr_ctl(wr_ctl), .ctl_bits(wr_data[BYTE_W-1:1]),
    .mode_wr(mode_wr), .latch_cmd(latch_cmd), .rb_cnt(rb_cnt),
    .rb_sts(rb_sts), .data_wr(data_wr)
  );

  tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .data_wr(data_wr),
    .wr_data(wr_data), .tick_edge(tick_edge), .count(count),
    .out(irq_out), .acc(acc), .status(status)
  );

  tmr_readout #(.CNT_W(CNT_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .latch_cmd(latch_cmd),
    .rb_cnt(rb_cnt), .rb_sts(rb_sts), .rd_en(rd_en), .acc(acc),
    .count(count), .status(status), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  assert_rw_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_en));
  assert_single_command_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mode_wr, latch_cmd, data_wr, rb_cnt | rb_sts}));
endmodule

// File: tb/tick_timer_tb.sv
module tick_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_ctl = 1'b0, rd_en = 1'b0, cnt_tick = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       rd_valid, irq_out;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  tick_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ctl(wr_ctl), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .cnt_tick(cnt_tick), .irq_out(irq_out)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic ctl, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_ctl = ctl; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); cnt_tick = 1'b1;
    @(negedge clk); cnt_tick = 1'b0;
  endtask

  task automatic rd(string tag, logic [7:0] exp);
    @(negedge clk); rd_en = 1'b1; exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic readback(string tag, logic [7:0] s, logic [7:0] lo, logic [7:0] hi);
    wr(1'b1, 8'hC2);
    rd({tag, " R11 status"}, s);
    rd({tag, " R11 count lo"}, lo);
    rd({tag, " R11 count hi"}, hi);
  endtask

  // monitor: pop expected bytes as the design returns them
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) chk("R12 unexpected rd_valid", 8'h01, 8'h00);
      else chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    chk("R1 irq after reset", {7'b0, irq_out}, 8'h00);
    readback("R1 reset", 8'h70, 8'h00, 8'h00);

    // one-shot flag, count 3
    wr(1'b1, 8'h30);
    wr(1'b0, 8'h03); wr(1'b0, 8'h00);
    readback("R4 before load", 8'h70, 8'h00, 8'h00);
    tick(); tick(); tick();
    chk("R6 low before terminal", {7'b0, irq_out}, 8'h00);
    rd("R13 live lo", 8'h01); rd("R13 live hi", 8'h00);
    tick();
    chk("R6 high at terminal", {7'b0, irq_out}, 8'h01);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R6 stays high", {7'b0, irq_out}, 8'h01);
    end
    @(negedge clk); cnt_tick = 1'b1;
    repeat (4) @(negedge clk);
    cnt_tick = 1'b0;
    rd("R5 held strobe lo", 8'hFC); rd("R5 held strobe hi", 8'hFF);

    // counter latch
    wr(1'b1, 8'h00);
    tick(); tick();
    wr(1'b1, 8'h00);
    rd("R10 latched lo", 8'hFC); rd("R10 latched hi", 8'hFF);
    rd("R10 live lo after", 8'hFA); rd("R10 live hi after", 8'hFF);

    // mode write halts
    wr(1'b1, 8'h30);
    chk("R3 one-shot output low", {7'b0, irq_out}, 8'h00);
    tick(); tick();
    readback("R3 halted", 8'h70, 8'hFA, 8'hFF);

    // rate generator, count 3
    wr(1'b1, 8'h34);
    chk("R3 rate output high", {7'b0, irq_out}, 8'h01);
    wr(1'b0, 8'h03); wr(1'b0, 8'h00);
    tick(); chk("R7 load", {7'b0, irq_out}, 8'h01);
    tick(); chk("R7 count 2", {7'b0, irq_out}, 8'h01);
    tick(); chk("R7 pulse low", {7'b0, irq_out}, 8'h00);
    tick(); chk("R7 reload high", {7'b0, irq_out}, 8'h01);
    tick(); chk("R7 second 2", {7'b0, irq_out}, 8'h01);
    tick(); chk("R7 second pulse", {7'b0, irq_out}, 8'h00);
    tick(); chk("R7 second reload", {7'b0, irq_out}, 8'h01);
    readback("R7 rate", 8'hB4, 8'h03, 8'h00);

    // ignored control bytes
    wr(1'b1, 8'h32);
    wr(1'b1, 8'h74);
    chk("R2 ignored keeps output", {7'b0, irq_out}, 8'h01);
    tick();
    readback("R2 ignored", 8'hB4, 8'h02, 8'h00);

    // a count byte halts, load on next edge
    wr(1'b0, 8'h05);
    tick(); tick();
    readback("R4 halted mid-write", 8'hF4, 8'h02, 8'h00);
    wr(1'b0, 8'h00);
    tick();
    readback("R4 loaded", 8'hB4, 8'h05, 8'h00);

    // one-shot strobe, low byte only
    wr(1'b1, 8'h18);
    chk("R3 strobe output high", {7'b0, irq_out}, 8'h01);
    wr(1'b0, 8'h02);
    tick(); chk("R8 load", {7'b0, irq_out}, 8'h01);
    tick(); chk("R8 count 1", {7'b0, irq_out}, 8'h01);
    tick(); chk("R8 strobe low", {7'b0, irq_out}, 8'h00);
    for (int i = 0; i < 4; i++) begin
      tick(); chk("R8 no repeat", {7'b0, irq_out}, 8'h01);
    end
    rd("R13 low-only read", 8'hFC); rd("R13 low-only again", 8'hFC);

    // high byte only
    wr(1'b1, 8'h20);
    wr(1'b0, 8'h01);
    tick();
    rd("R4 high-only load", 8'h01);
    tick();
    rd("R13 high-only read", 8'h00);

    // zero initial count
    wr(1'b1, 8'h30);
    wr(1'b0, 8'h00); wr(1'b0, 8'h00);
    tick();
    readback("R9 zero loaded", 8'h30, 8'h00, 8'h00);
    tick();
    rd("R9 wrap lo", 8'hFF); rd("R9 wrap hi", 8'hFF);
    chk("R9 not terminal", {7'b0, irq_out}, 8'h00);

    // read-back of count only, then status only
    wr(1'b1, 8'hD2);
    tick();
    rd("R11 count-only lo", 8'hFF); rd("R11 count-only hi", 8'hFF);
    wr(1'b1, 8'hE2);
    rd("R11 status-only", 8'h30);

    repeat (4) @(negedge clk);
    chk("R12 no valid when idle", {7'b0, rd_valid}, 8'h00);
    chk("R12 all reads answered", 8'(exp_q.size()), 8'h00);
    finish_run();
  end
endmodule